// File: doc/BRIEF.md
# Pipelined Truncating Unsigned Multiplier

This block multiplies two unsigned operands and returns only the low half of the product, as wide as one operand. Both operands are sampled into a register bank on entry, and the result leaves through a register on exit, so no path runs directly from an input pin to the output. The partial-product rows are summed in segments. A build-time depth parameter places a chosen number of register stages between those segments. Each extra stage shortens the longest register-to-register path and adds exactly one cycle of latency.

A new operand pair may be presented on every clock; there is no stall. A qualifier bit enters beside the operands and follows the data through the same number of registers, so a consumer knows which output words carry real results. One asynchronous clear empties every register at once, including the qualifier chain. The block has no enable and no synchronous load: every register holds data, clear and clock only.

Top module: `mulPipeTrunc`

## Requirements
- R1: `product` equals bits [OP_W-1:0] of the full unsigned product `opA * opB`. All higher bits are discarded (for example, 255 x 255 gives 1 and 16 x 16 gives 0).
- R2: A pair sampled at a rising edge appears on `product` after exactly CORE_DEPTH+2 rising edges, counting the sampling edge. It is not visible one edge earlier.
- R3: A new pair is taken on every edge. A run of at least 50 back-to-back pairs yields every product, in order, at the fixed latency.
- R4: `outValid` repeats `inValid` with the same CORE_DEPTH+2 edge delay as the data, including isolated pulses and gaps.
- R5: While `clrAsync` is high, `product` and `outValid` are 0 with no clock edge needed. This holds from the moment of assertion.
- R6: Results still in flight when the clear arrives are lost. After release, `outValid` and `product` stay 0 until the first pair sampled after release reaches the output.
- R7: CORE_DEPTH may be 0, 1, 2 or 4. At 0 no register sits between the input and output banks, and the latency is 2 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for every register |
| clrAsync | input | 1 | Asynchronous clear, active high |
| inValid | input | 1 | Qualifier for the operand pair on this edge |
| opA | input | OP_W | Multiplicand, unsigned |
| opB | input | OP_W | Multiplier, unsigned |
| outValid | output | 1 | Qualifier delayed to match `product` |
| product | output | OP_W | Low OP_W bits of opA*opB, registered |

## Verification
The bench builds two copies side by side from the same stimulus. One has CORE_DEPTH 4, which is the deepest staging and uses five row segments with four inner registers. The other has CORE_DEPTH 0, where the single segment sits directly between the input and output banks. Between them they cover the six-edge and two-edge latencies, the register chain and the bypass branch of the generate. A mid-stream clear shows in both builds that results in flight are dropped.

// File: rtl/mulPipePkg.sv
package mulPipePkg;

  // Strobes sent from the control half to the top.
  typedef struct packed {
    logic emitLive;   // qualifier at the output register
  } laneStrobe_t;

endpackage

// File: rtl/mulPipeCtrl.sv
module mulPipeCtrl
  import mulPipePkg::*;
#(
  parameter int CORE_DEPTH = 4
) (
  input  logic        clk,
  input  logic        clrAsync,
  input  logic        inValid,
  output laneStrobe_t strobes
);

  localparam int LAT = CORE_DEPTH + 2;

  logic [LAT-1:0] validChain;

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) validChain <= '0;
    else          validChain <= {validChain[LAT-2:0], inValid};
  end

  assign strobes.emitLive = validChain[LAT-1];

endmodule

// File: rtl/mulPipeData.sv
module mulPipeData #(
  parameter int OP_W       = 8,
  parameter int CORE_DEPTH = 4
) (
  input  logic            clk,
  input  logic            clrAsync,
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output logic [OP_W-1:0] product
);

  localparam int SEG = CORE_DEPTH + 1;            // row segments
  localparam int RPS = (OP_W + SEG - 1) / SEG;    // rows per segment

  typedef struct packed {
    logic [OP_W-1:0] a;
    logic [OP_W-1:0] b;
    logic [OP_W-1:0] acc;
  } lane_t;

  // Adds shifted copies of a for the rows of b in [lo, hi). Bits above
  // OP_W fall off the shift, which gives the truncated product.
  function automatic logic [OP_W-1:0] addRows(
    input logic [OP_W-1:0] acc,
    input logic [OP_W-1:0] a,
    input logic [OP_W-1:0] b,
    input int              lo,
    input int              hi
  );
    logic [OP_W-1:0] sum;
    sum = acc;
    for (int i = 0; i < OP_W; i++) begin
      if (i >= lo && i < hi && b[i]) sum = sum + (a << i);
    end
    return sum;
  endfunction

  logic [OP_W-1:0] inA, inB;
  lane_t           headLane;
  lane_t           segIn  [0:SEG-1];
  logic [OP_W-1:0] segSum [0:SEG-1];

  // Input bank
  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) begin
      inA <= '0;
      inB <= '0;
    end else begin
      inA <= opA;
      inB <= opB;
    end
  end

  assign headLane = '{a: inA, b: inB, acc: '0};

  // Row segments
  always_comb begin
    for (int s = 0; s < SEG; s++) begin
      segSum[s] = addRows(segIn[s].acc, segIn[s].a, segIn[s].b,
                          s * RPS, (s + 1) * RPS);
    end
  end

  generate
    if (CORE_DEPTH > 0) begin : g_staged
      lane_t stageReg [0:CORE_DEPTH-1];

      always_ff @(posedge clk or posedge clrAsync) begin
        if (clrAsync) begin
          for (int s = 0; s < CORE_DEPTH; s++) stageReg[s] <= '0;
        end else begin
          for (int s = 0; s < CORE_DEPTH; s++) begin
            stageReg[s] <= '{a: segIn[s].a, b: segIn[s].b, acc: segSum[s]};
          end
        end
      end

      always_comb begin
        segIn[0] = headLane;
        for (int s = 1; s < SEG; s++) segIn[s] = stageReg[s-1];
      end
    end else begin : g_flat
      always_comb segIn[0] = headLane;
    end
  endgenerate

  // Output bank
  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) product <= '0;
    else          product <= segSum[SEG-1];
  end

endmodule

// File: rtl/mulPipeTrunc.sv
module mulPipeTrunc
  import mulPipePkg::*;
#(
  parameter int OP_W       = 8,
  parameter int CORE_DEPTH = 4
) (
  input  logic            clk,
  input  logic            clrAsync,
  input  logic            inValid,
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output logic            outValid,
  output logic [OP_W-1:0] product
);

  laneStrobe_t strobes;

  generate
    if (!(CORE_DEPTH == 0 || CORE_DEPTH == 1 ||
          CORE_DEPTH == 2 || CORE_DEPTH == 4)) begin : g_badDepth
      $error("mulPipeTrunc: CORE_DEPTH must be 0, 1, 2 or 4");
    end
  endgenerate

  mulPipeCtrl #(.CORE_DEPTH(CORE_DEPTH)) u_ctrl (
    .clk      (clk),
    .clrAsync (clrAsync),
    .inValid  (inValid),
    .strobes  (strobes)
  );

  mulPipeData #(.OP_W(OP_W), .CORE_DEPTH(CORE_DEPTH)) u_data (
    .clk      (clk),
    .clrAsync (clrAsync),
    .opA      (opA),
    .opB      (opB),
    .product  (product)
  );

  assign outValid = strobes.emitLive;

endmodule

// File: rtl/mulPipeTruncChk.sv
module mulPipeTruncChk #(
  parameter int OP_W       = 8,
  parameter int CORE_DEPTH = 4
) (
  input logic            clk,
  input logic            clrAsync,
  input logic            inValid,
  input logic [OP_W-1:0] opA,
  input logic [OP_W-1:0] opB,
  input logic            outValid,
  input logic [OP_W-1:0] product
);

  localparam int LAT = CORE_DEPTH + 2;

  logic [2*OP_W-1:0] fullProd;
  logic [OP_W-1:0]   refProd;
  int                sinceClr;

  assign fullProd = opA * opB;
  assign refProd  = fullProd[OP_W-1:0];

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync)            sinceClr <= 0;
    else if (sinceClr < LAT) sinceClr <= sinceClr + 1;
  end

  AST_TRUNC_PRODUCT: assert property (@(posedge clk) disable iff (clrAsync)
    (sinceClr >= LAT) |-> (product == $past(refProd, LAT)));             // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (clrAsync)
    (sinceClr >= LAT) |-> (outValid == $past(inValid, LAT)));            // R4
  AST_CLEAR_EMPTIES: assert property (@(negedge clk)
    clrAsync |-> (product == '0 && !outValid));                          // R5
  AST_QUIET_AFTER_CLEAR: assert property (@(posedge clk) disable iff (clrAsync)
    (sinceClr < LAT) |-> !outValid);                                     // R6
  AST_OUTPUT_KNOWN: assert property (@(posedge clk) disable iff (clrAsync)
    !$isunknown({outValid, product}));                                   // R2

endmodule

bind mulPipeTrunc mulPipeTruncChk #(.OP_W(OP_W), .CORE_DEPTH(CORE_DEPTH)) u_chk (
  .clk      (clk),
  .clrAsync (clrAsync),
  .inValid  (inValid),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .product  (product)
);

// File: tb/test_mulPipeTrunc.sv
module test_mulPipeTrunc;

  localparam int CLK_PERIOD = 10;
  localparam int OP_W       = 8;
  localparam int LAT_DEEP   = 6;   // CORE_DEPTH 4
  localparam int LAT_FLAT   = 2;   // CORE_DEPTH 0
  localparam int HIST       = 64;

  logic clk = 1'b0;
  logic clrAsync = 1'b1;
  logic inValid = 1'b0;
  logic [OP_W-1:0] opA = '0, opB = '0;
  logic outValidDeep, outValidFlat;
  logic [OP_W-1:0] productDeep, productFlat;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  logic [OP_W-1:0] hA [HIST];
  logic [OP_W-1:0] hB [HIST];
  logic            hV [HIST];

  always #(CLK_PERIOD/2) clk = ~clk;

  mulPipeTrunc #(.OP_W(OP_W), .CORE_DEPTH(4)) i_mulPipeTrunc (
    .clk(clk), .clrAsync(clrAsync), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValidDeep), .product(productDeep)
  );

  mulPipeTrunc #(.OP_W(OP_W), .CORE_DEPTH(0)) i_mulPipeTrunc_flat (
    .clk(clk), .clrAsync(clrAsync), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValidFlat), .product(productFlat)
  );

  task automatic check(input string tag, input string what,
                       input logic [OP_W-1:0] act, input logic [OP_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic clearHistory();
    for (int i = 0; i < HIST; i++) begin
      hA[i] = '0; hB[i] = '0; hV[i] = 1'b0;
    end
  endtask

  task automatic compareOne(input string tag, input string inst, input int lat,
                            input logic [OP_W-1:0] actP, input logic actV);
    logic [2*OP_W-1:0] full;
    logic              expV;
    int                idx;
    idx = cyc - lat;
    if (idx < 0) begin
      full = '0; expV = 1'b0;
    end else begin
      full = hA[idx % HIST] * hB[idx % HIST];
      expV = hV[idx % HIST];
    end
    check(tag, {inst, " product"}, actP, full[OP_W-1:0]);
    check(tag, {inst, " outValid"}, {{(OP_W-1){1'b0}}, actV}, {{(OP_W-1){1'b0}}, expV});
  endtask

  // One cycle: sample both builds at the negedge, then drive the next pair.
  task automatic step(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                      input logic v, input string tag);
    @(negedge clk);
    compareOne(tag, "depth4", LAT_DEEP, productDeep, outValidDeep);
    compareOne({tag, " R7"}, "depth0", LAT_FLAT, productFlat, outValidFlat);
    opA = a; opB = b; inValid = v;
    hA[cyc % HIST] = clrAsync ? '0 : a;
    hB[cyc % HIST] = clrAsync ? '0 : b;
    hV[cyc % HIST] = clrAsync ? 1'b0 : v;
    cyc++;
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < LAT_DEEP; i++) step('0, '0, 1'b0, tag);
  endtask

  task automatic testReset();
    // R5: clear held from time zero empties both builds.
    #1;
    check("R5", "depth4 product at reset", productDeep, '0);
    check("R5", "depth4 outValid at reset", {7'd0, outValidDeep}, '0);
    check("R5", "depth0 product at reset", productFlat, '0);
    @(negedge clk);
    @(negedge clk);
    clrAsync = 1'b0;
    cyc = 0;
    clearHistory();
  endtask

  task automatic testCorners();
    // R1: truncation corners
    step(8'd255, 8'd255, 1'b1, "R1");   // 65025 -> 1
    step(8'd16,  8'd16,  1'b1, "R1");   // 256 -> 0
    step(8'd15,  8'd17,  1'b1, "R1");   // 255
    step(8'd0,   8'd200, 1'b1, "R1");
    step(8'd1,   8'd173, 1'b1, "R1");
    step(8'd128, 8'd3,   1'b1, "R1");   // 384 -> 128
    step(8'd37,  8'd11,  1'b1, "R1");   // 407 -> 151
    flush("R1");
  endtask

  task automatic testLatency();
    // R2: a lone pulse arrives exactly at the fixed latency
    step(8'd9, 8'd7, 1'b1, "R2");
    for (int i = 0; i < LAT_DEEP + 1; i++) step('0, '0, 1'b0, "R2");
  endtask

  task automatic testStream();
    // R3: 60 back-to-back pairs
    for (int i = 0; i < 60; i++) step(OP_W'($urandom), OP_W'($urandom), 1'b1, "R3");
    flush("R3");
  endtask

  task automatic testBubbles();
    // R4: qualifier pattern with gaps
    for (int i = 0; i < 20; i++)
      step(OP_W'($urandom), OP_W'($urandom), (i % 3) != 1, "R4");
    flush("R4");
  endtask

  task automatic testMidClear();
    for (int i = 0; i < 5; i++) step(OP_W'(i + 3), OP_W'(i + 50), 1'b1, "R6");
    #2 clrAsync = 1'b1;
    #1;
    check("R5", "depth4 product on clear", productDeep, '0);
    check("R5", "depth4 outValid on clear", {7'd0, outValidDeep}, '0);
    check("R5", "depth0 product on clear", productFlat, '0);
    check("R5", "depth0 outValid on clear", {7'd0, outValidFlat}, '0);
    clearHistory();
    @(negedge clk);
    clrAsync = 1'b0;
    opA = '0; opB = '0; inValid = 1'b0;
    cyc++;
    // R6: nothing from before the clear may surface
    for (int i = 0; i < 4; i++) step(OP_W'(i + 20), 8'd13, 1'b1, "R6");
    flush("R6");
  endtask

  initial begin
    clearHistory();
    testReset();
    testCorners();
    testLatency();
    testStream();
    testBubbles();
    testMidClear();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule